// File: doc/BRIEF.md
# Power-On Configuration Sequencer

This block steers the power-up of a programmable-logic device. It starts from digitized supply-good flags: one for the core rail and one per I/O bank. When the core rail is good, it asks an external transfer engine to copy the configuration image from non-volatile storage into volatile configuration memory. It then waits for that engine to report completion.

Throughout this phase every user pin is held high-impedance with its weak pull-up enabled. User mode is entered only after the image is loaded, every I/O bank is powered, and the banks have stayed powered for a fixed settle time. After that the pins are handed to user logic. User mode is sticky: from then on the core flag is no longer watched, and only a hard reset leaves user mode.

A timeout counter raises a sticky error flag if the transfer engine does not report completion within the maximum configuration time. All supply flags cross into the clock domain through two-flop synchronizers before the controller uses them.

Top module: `por_cfg_seq`

## Requirements
- R1: While `rst` is high at a rising edge, and after it, `cfg_req_o`=0, `user_mode_o`=0, `cfg_err_o`=0, `pad_hiz_o`=1 and `pad_pullup_o`=1.
- R2: The supply flags are synchronized. When `core_ok_i` rises before rising edge 1, `cfg_req_o` goes high after edge 3.
- R3: `cfg_req_o` stays high until the controller, already requesting before the edge, samples `cfg_done_i`=1 at a rising edge. It then goes low after that edge and is never high in user mode.
- R4: `pad_hiz_o` and `pad_pullup_o` are both 1 in every cycle before user mode. Both go to 0 on the same edge at which `user_mode_o` rises.
- R5: User mode is never entered while any bit of `bank_ok_i` is low.
- R6: Let W be the edge at which the done handshake is accepted, and let the last bank flag rise before edge B+1. The settle phase starts at edge max(W+1, B+3). `user_mode_o` rises exactly SETTLE_CYCLES edges later, where SETTLE_CYCLES = SETTLE_NS*CLK_MHZ/1000.
- R7: If any bank flag drops during the settle phase, the controller goes back to waiting for the banks. The full settle count restarts once all banks are good again.
- R8: If the core flag drops before user mode, the controller returns to its idle state. A fresh request is issued 3 edges after the core flag returns.
- R9: Once `user_mode_o` is 1, it stays 1 and `cfg_req_o` stays 0 until reset, whatever `core_ok_i` does.
- R10: Count edges from the one that raises `cfg_req_o`. If the done handshake has not been accepted by the CFG_TIMEOUT_CYCLES-th such edge, `cfg_err_o` rises on that edge and stays high until reset. A done that is sampled on that same edge wins, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high hard reset |
| core_ok_i | input | 1 | Core supply above threshold (asynchronous) |
| bank_ok_i | input | NUM_BANKS | Per-bank I/O supply good (asynchronous) |
| cfg_done_i | input | 1 | Transfer engine reports image loaded (clock domain) |
| cfg_req_o | output | 1 | Request to copy the image into configuration memory |
| pad_hiz_o | output | 1 | Force all user pins to high impedance |
| pad_pullup_o | output | 1 | Enable weak pull-ups on all user pins |
| user_mode_o | output | 1 | Device is in user mode |
| cfg_err_o | output | 1 | Sticky download timeout error |

## Verification
The collision of interest is the final cycle of the download timeout landing on the same edge as the done handshake. The bench provokes it by raising `cfg_done_i` exactly in the cycle whose edge ends the timeout window, and then again one cycle later. It judges the result by `cfg_err_o`, which must stay 0 in the first case and rise on the window-ending edge in the second. In both cases the user-mode edge is checked against the formula in R6.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_LOAD   = 3'd1,
    SEQ_BANKS  = 3'd2,
    SEQ_SETTLE = 3'd3,
    SEQ_USER   = 3'd4
  } seq_state_t;

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i)  cnt <= RELOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired_o = run_i && (cnt == '0);

endmodule

// File: rtl/por_cfg_seq.sv
module por_cfg_seq
  import por_pkg::*;
#(
  parameter int NUM_BANKS          = 4,
  parameter int SYNC_STAGES        = 2,
  parameter int CLK_MHZ            = 100,
  parameter int SETTLE_NS          = 2000,
  parameter int CFG_TIMEOUT_CYCLES = 45000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 core_ok_i,
  input  logic [NUM_BANKS-1:0] bank_ok_i,
  input  logic                 cfg_done_i,
  output logic                 cfg_req_o,
  output logic                 pad_hiz_o,
  output logic                 pad_pullup_o,
  output logic                 user_mode_o,
  output logic                 cfg_err_o
);

  localparam int SETTLE_CYCLES = (SETTLE_NS * CLK_MHZ) / 1000;

  logic                 core_s;
  logic [NUM_BANKS-1:0] bank_s;
  logic                 banks_up;
  logic                 settle_done;
  logic                 load_late;
  seq_state_t           state_q, state_d;

  por_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_core_sync (
    .clk(clk), .rst(rst), .d_i(core_ok_i), .q_o(core_s)
  );

  por_sync #(.WIDTH(NUM_BANKS), .STAGES(SYNC_STAGES)) u_bank_sync (
    .clk(clk), .rst(rst), .d_i(bank_ok_i), .q_o(bank_s)
  );

  assign banks_up = &bank_s;

  por_timer #(.LIMIT(SETTLE_CYCLES)) u_settle_tmr (
    .clk(clk), .rst(rst), .run_i(state_q == SEQ_SETTLE), .expired_o(settle_done)
  );

  por_timer #(.LIMIT(CFG_TIMEOUT_CYCLES)) u_load_tmr (
    .clk(clk), .rst(rst), .run_i(state_q == SEQ_LOAD), .expired_o(load_late)
  );

  // Core flag is watched in every state except user mode.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (core_s) state_d = SEQ_LOAD;
      SEQ_LOAD: begin
        if (!core_s)         state_d = SEQ_IDLE;
        else if (cfg_done_i) state_d = SEQ_BANKS;
      end
      SEQ_BANKS: begin
        if (!core_s)       state_d = SEQ_IDLE;
        else if (banks_up) state_d = SEQ_SETTLE;
      end
      SEQ_SETTLE: begin
        if (!core_s)          state_d = SEQ_IDLE;
        else if (!banks_up)   state_d = SEQ_BANKS;
        else if (settle_done) state_d = SEQ_USER;
      end
      SEQ_USER:   state_d = SEQ_USER;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_IDLE;
      cfg_req_o    <= 1'b0;
      pad_hiz_o    <= 1'b1;
      pad_pullup_o <= 1'b1;
      user_mode_o  <= 1'b0;
      cfg_err_o    <= 1'b0;
    end else begin
      state_q      <= state_d;
      cfg_req_o    <= (state_d == SEQ_LOAD);
      pad_hiz_o    <= (state_d != SEQ_USER);
      pad_pullup_o <= (state_d != SEQ_USER);
      user_mode_o  <= (state_d == SEQ_USER);
      // A done sampled in the expiry cycle takes precedence.
      if (load_late && !cfg_done_i) cfg_err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/por_cfg_seq_chk.sv
module por_cfg_seq_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 core_s,
  input logic [NUM_BANKS-1:0] bank_s,
  input logic                 cfg_req_o,
  input logic                 pad_hiz_o,
  input logic                 pad_pullup_o,
  input logic                 user_mode_o,
  input logic                 cfg_err_o
);

  a_r2_req_needs_core: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_o) |-> $past(core_s));

  a_r3_req_not_in_user: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req_o && user_mode_o));

  a_r4_pads_held: assert property (@(posedge clk) disable iff (rst)
    !user_mode_o |-> (pad_hiz_o && pad_pullup_o));

  a_r4_pads_released: assert property (@(posedge clk) disable iff (rst)
    user_mode_o |-> (!pad_hiz_o && !pad_pullup_o));

  a_r5_banks_up: assert property (@(posedge clk) disable iff (rst)
    $rose(user_mode_o) |-> $past(&bank_s));

  a_r9_user_sticky: assert property (@(posedge clk) disable iff (rst)
    user_mode_o |=> user_mode_o);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> cfg_err_o);

endmodule

bind por_cfg_seq por_cfg_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .core_s(core_s), .bank_s(bank_s),
  .cfg_req_o(cfg_req_o), .pad_hiz_o(pad_hiz_o), .pad_pullup_o(pad_pullup_o),
  .user_mode_o(user_mode_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_por_cfg_seq.sv
module tb_por_cfg_seq;

  localparam int NB     = 3;
  localparam int SETTLE = 20;   // 200 ns at 100 MHz
  localparam int TMO    = 50;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          core_ok = 1'b0;
  logic [NB-1:0] bank_ok = '0;
  logic          done = 1'b0;
  logic          req, hiz, pull, user, err;

  int errs = 0;
  int checks = 0;
  int k = 0;

  always #5 clk = ~clk;

  por_cfg_seq #(
    .NUM_BANKS(NB), .SYNC_STAGES(2), .CLK_MHZ(100),
    .SETTLE_NS(200), .CFG_TIMEOUT_CYCLES(TMO)
  ) dut (
    .clk(clk), .rst(rst), .core_ok_i(core_ok), .bank_ok_i(bank_ok),
    .cfg_done_i(done), .cfg_req_o(req), .pad_hiz_o(hiz),
    .pad_pullup_o(pull), .user_mode_o(user), .cfg_err_o(err)
  );

  // rows: done index D, bank index B, expected error
  localparam int VEC [5][3] = '{
    '{5,  0,  0},
    '{10, 40, 0},
    '{2,  1,  0},
    '{52, 0,  0},   // done in the timeout expiry cycle
    '{53, 0,  1}    // done one cycle too late
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    k++;
  endtask

  task automatic do_reset();
    rst = 1'b1; core_ok = 1'b0; bank_ok = '0; done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req", req, 0); chk("R1 user", user, 0); chk("R1 err", err, 0);
    chk("R1 hiz", hiz, 1); chk("R1 pullup", pull, 1);
    rst = 1'b0;
    k = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // Vector table
    for (int r = 0; r < 5; r++) begin
      int d, b, w, s, u;
      d = VEC[r][0]; b = VEC[r][1];
      w = (d + 1 > 4) ? d + 1 : 4;
      s = (w + 1 > b + 3) ? w + 1 : b + 3;
      u = s + SETTLE;
      do_reset();
      for (int c = 0; c <= u + 2; c++) begin
        core_ok = 1'b1;
        bank_ok = (c >= b) ? '1 : '0;
        done    = (c >= d);
        tick();
        if (k == 2)     chk("R2 req early", req, 0);
        if (k == 3)     chk("R2 req rise", req, 1);
        if (k == w - 1) chk("R3 req held", req, 1);
        if (k == w)     chk("R3 req drop", req, 0);
        if (k == u - 1) begin
          chk("R6 user early", user, 0); chk("R4 hiz held", hiz, 1);
          chk("R4 pullup held", pull, 1);
        end
        if (k == u) begin
          chk("R6 user rise", user, 1); chk("R4 hiz free", hiz, 0);
          chk("R4 pullup free", pull, 0); chk("R10 err", err, VEC[r][2]);
        end
      end
    end

    // R7: bank drop during settle restarts the count
    do_reset();
    core_ok = 1'b1; bank_ok = '1;
    while (k < 40) begin
      if (k == 2)  done = 1'b1;
      if (k == 9)  bank_ok[0] = 1'b0;
      if (k == 14) bank_ok[0] = 1'b1;
      tick();
      if (k == 25) chk("R7 no user at old time", user, 0);
      if (k == 36) chk("R7 user early", user, 0);
      if (k == 37) chk("R7 user after restart", user, 1);
    end

    // R8: core drop before user mode returns to idle
    do_reset();
    core_ok = 1'b1;
    while (k < 30) begin
      if (k == 2)  done = 1'b1;
      if (k == 10) core_ok = 1'b0;
      if (k == 20) core_ok = 1'b1;
      tick();
      if (k == 22) chk("R8 idle no req", req, 0);
      if (k == 23) chk("R8 req reissued", req, 1);
      if (k == 24) chk("R8 req accepted", req, 0);
    end

    // R10: timeout with no done, then late done still completes
    do_reset();
    core_ok = 1'b1; bank_ok = '1;
    while (k < 85) begin
      if (k == 60) done = 1'b1;
      tick();
      if (k == 52) chk("R10 err early", err, 0);
      if (k == TMO + 3) begin
        chk("R10 err rise", err, 1); chk("R10 req held", req, 1);
      end
      if (k == 81) chk("R6 late user early", user, 0);
      if (k == 82) begin
        chk("R6 late user", user, 1); chk("R10 err sticky", err, 1);
      end
    end

    // R5: missing bank blocks user mode; then R9 core ignored
    do_reset();
    core_ok = 1'b1; bank_ok = 3'b011;
    while (k < 140) begin
      if (k == 2)   done = 1'b1;
      if (k == 100) bank_ok = '1;
      if (k == 125) core_ok = 1'b0;
      tick();
      if (k == 100) begin
        chk("R5 user blocked", user, 0); chk("R5 hiz held", hiz, 1);
      end
      if (k == 122) chk("R6 user early", user, 0);
      if (k == 123) chk("R6 user rise", user, 1);
    end
    chk("R9 user kept", user, 1);
    chk("R9 req stays low", req, 0);
    chk("R9 pads free", hiz, 0);

    // R1: reset from user mode
    do_reset();
    tick();
    chk("R1 after exit user", user, 0);
    chk("R1 hiz after exit", hiz, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule